// File: doc/BRIEF.md
# Quad-precision negative multiply-add commit stage

This stage takes the already rounded 128-bit result of a quad-precision fused multiply-add, along with the raw exception indications raised by the arithmetic core. It turns that into the architected outcome of a negative multiply-add instruction. The stage flips the sign of the rounded value, leaving NaNs untouched, and derives a 5-bit class code from the negated value. It accumulates sticky exception status, sets a summary bit whenever a status bit first becomes set, and refreshes the two per-instruction rounding indicators. It decides whether the destination register is written. It also maps the 5-bit operand fields onto the upper half of a 64-entry register file and raises a trap when the vector facility is disabled.

The input side is a valid-qualified stream without back-pressure. Every cycle with `in_valid` high is one instruction, and it is consumed in that cycle. The write port (`wr_en`, `wr_idx`, `wr_data`), the class code, the status and the trap pulse are all registered, so they appear one cycle after the accepted instruction. The register-file consumer must always accept a write; there is no stall path. The control and status pins are plain levels.

Top module: `qfp_commit`

## Requirements
- R1: An instruction with `fac_en`=0 pulses `trap` high in the next cycle. It produces no write (`wr_en`=0) and leaves `sticky`, `exc_sum`, `frac_rnd`, `frac_inx` and `res_class` unchanged.
- R2: The physical register index is the 5-bit field plus 32. `wr_idx` is the registered value of `dst_fld`+32, and `rd_a_idx`/`rd_b_idx` are the combinational values of `src_a_fld`+32 and `src_b_fld`+32.
- R3: `wr_data` is `res_in` with bit 127 inverted. The exception is a NaN input, meaning exponent bits 126:112 are all ones and fraction bits 111:0 are nonzero, which is passed through unchanged.
- R4: `res_class` is updated on each committed write and takes the class of the negated value. The codes are: any NaN 10001, -inf 01001, -normal 01000, -denormal 11000, -zero 10010, +zero 00010, +denormal 10100, +normal 00100, +inf 00101.
- R5: When `inv_en`=1 and any of `flag_snan`, `flag_imz`, `flag_isi` is 1, the instruction produces no write and `res_class` keeps its previous value. With `inv_en`=0, or with none of those three flags set, the write takes place.
- R6: On each enabled instruction, each raised flag ORs into its own `sticky` bit: bit0 snan, bit1 inf-times-zero, bit2 inf-minus-inf, bit3 overflow, bit4 underflow, bit5 inexact. Bits stay set until reset.
- R7: `exc_sum` is set when an instruction sets a `sticky` bit that was 0. It stays 0 while no flag is raised and never falls outside reset.
- R8: On every enabled instruction, `frac_rnd` is overwritten with `flag_inc` AND NOT invalid, and `frac_inx` is overwritten with `flag_inx` AND NOT invalid. Here invalid is snan OR inf-times-zero OR inf-minus-infinity.
- R9: Cycles with `in_valid`=0 give `wr_en`=0 and `trap`=0 in the following cycle.
- R10: After reset, `wr_en`, `trap`, `sticky`, `exc_sum`, `frac_rnd`, `frac_inx` and `res_class` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| fac_en | input | 1 | Vector facility enabled |
| inv_en | input | 1 | Invalid-operation exception enabled |
| res_in | input | 128 | Rounded multiply-add result |
| dst_fld | input | 5 | Destination operand field |
| src_a_fld | input | 5 | First source operand field |
| src_b_fld | input | 5 | Second source operand field |
| flag_snan | input | 1 | Signaling-NaN operand seen |
| flag_imz | input | 1 | Infinity times zero |
| flag_isi | input | 1 | Infinity minus infinity |
| flag_ovf | input | 1 | Overflow |
| flag_unf | input | 1 | Underflow |
| flag_inx | input | 1 | Inexact |
| flag_inc | input | 1 | Fraction was incremented by rounding |
| rd_a_idx | output | 6 | Physical index of first source |
| rd_b_idx | output | 6 | Physical index of second source |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 6 | Physical destination index |
| wr_data | output | 128 | Negated result |
| trap | output | 1 | Facility-unavailable trap pulse |
| sticky | output | 6 | Sticky exception bits |
| exc_sum | output | 1 | Sticky exception summary |
| frac_rnd | output | 1 | Last instruction rounded up |
| frac_inx | output | 1 | Last instruction inexact |
| res_class | output | 5 | Class code of last written result |

## Verification
The negation and classification path is driven with one value from every class of both signs. Those are normals, zeros, denormals, infinities, a positive quiet NaN and a negative NaN, which together distinguish a sign flip from NaN pass-through and separate each exponent/fraction region. The register-index mapping is exercised at the field extremes 0 and 31. The same table holds invalid instructions with `inv_en` set and cleared, which shows that only an enabled invalid suppresses the write and freezes the class. Directed sequences then raise the flags one group at a time: this separates sticky accumulation from the per-instruction rounding bits, shows that invalid conditions mask those bits, and shows that a disabled facility leaves every piece of state untouched.

// File: rtl/qfp_commit_pkg.sv
package qfp_commit_pkg;

  typedef logic [4:0] cls_t;

  localparam cls_t CLS_QNAN  = 5'b10001;
  localparam cls_t CLS_NINF  = 5'b01001;
  localparam cls_t CLS_NNORM = 5'b01000;
  localparam cls_t CLS_NDEN  = 5'b11000;
  localparam cls_t CLS_NZERO = 5'b10010;
  localparam cls_t CLS_PZERO = 5'b00010;
  localparam cls_t CLS_PDEN  = 5'b10100;
  localparam cls_t CLS_PNORM = 5'b00100;
  localparam cls_t CLS_PINF  = 5'b00101;

  // Sticky status layout; first member is the MSB.
  typedef struct packed {
    logic inx;   // bit5
    logic unf;   // bit4
    logic ovf;   // bit3
    logic isi;   // bit2
    logic imz;   // bit1
    logic snan;  // bit0
  } stk_t;

endpackage

// File: rtl/qfp_negate_class.sv
module qfp_negate_class
  import qfp_commit_pkg::*;
#(
  parameter int W    = 128,
  parameter int EXPW = 15
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output cls_t         cls
);
  localparam int FRACW = W - 1 - EXPW;

  logic [EXPW-1:0]  ex;
  logic [FRACW-1:0] fr;
  logic             ex_ones, ex_zero, fr_zero, is_nan, nsign;

  assign ex      = din[W-2 -: EXPW];
  assign fr      = din[FRACW-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign fr_zero = ~|fr;
  assign is_nan  = ex_ones & ~fr_zero;

  assign dout  = is_nan ? din : {~din[W-1], din[W-2:0]};
  assign nsign = dout[W-1];

  always_comb begin
    if (is_nan)                 cls = CLS_QNAN;
    else if (ex_ones)           cls = nsign ? CLS_NINF  : CLS_PINF;
    else if (ex_zero & fr_zero) cls = nsign ? CLS_NZERO : CLS_PZERO;
    else if (ex_zero)           cls = nsign ? CLS_NDEN  : CLS_PDEN;
    else                        cls = nsign ? CLS_NNORM : CLS_PNORM;
  end
endmodule

// File: rtl/qfp_status_upd.sv
module qfp_status_upd
  import qfp_commit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  stk_t raised,
  input  logic inv_any,
  input  logic inx,
  input  logic inc,
  output stk_t sticky,
  output logic exc_sum,
  output logic frac_rnd,
  output logic frac_inx
);
  stk_t fresh;
  assign fresh = raised & ~sticky;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky   <= '0;
      exc_sum  <= 1'b0;
      frac_rnd <= 1'b0;
      frac_inx <= 1'b0;
    end else if (upd) begin
      sticky   <= sticky | raised;
      if (|fresh) exc_sum <= 1'b1;
      frac_rnd <= inc & ~inv_any;
      frac_inx <= inx & ~inv_any;
    end
  end
endmodule

// File: rtl/qfp_commit.sv
module qfp_commit
  import qfp_commit_pkg::*;
#(
  parameter int W    = 128,
  parameter int EXPW = 15,
  parameter int FLDW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              fac_en,
  input  logic              inv_en,
  input  logic [W-1:0]      res_in,
  input  logic [FLDW-1:0]   dst_fld,
  input  logic [FLDW-1:0]   src_a_fld,
  input  logic [FLDW-1:0]   src_b_fld,
  input  logic              flag_snan,
  input  logic              flag_imz,
  input  logic              flag_isi,
  input  logic              flag_ovf,
  input  logic              flag_unf,
  input  logic              flag_inx,
  input  logic              flag_inc,
  output logic [FLDW:0]     rd_a_idx,
  output logic [FLDW:0]     rd_b_idx,
  output logic              wr_en,
  output logic [FLDW:0]     wr_idx,
  output logic [W-1:0]      wr_data,
  output logic              trap,
  output logic [5:0]        sticky,
  output logic              exc_sum,
  output logic              frac_rnd,
  output logic              frac_inx,
  output logic [4:0]        res_class
);
  localparam int IDXW = FLDW + 1;

  function automatic logic [IDXW-1:0] upper(input logic [FLDW-1:0] f);
    return {1'b1, f};
  endfunction

  assign rd_a_idx = upper(src_a_fld);
  assign rd_b_idx = upper(src_b_fld);

  logic [W-1:0] neg_val;
  cls_t         neg_cls;

  qfp_negate_class #(.W(W), .EXPW(EXPW)) u_neg (
    .din  (res_in),
    .dout (neg_val),
    .cls  (neg_cls)
  );

  logic go, inv_any, commit;
  stk_t raised, stk_q;

  assign go      = in_valid & fac_en;
  assign inv_any = flag_snan | flag_imz | flag_isi;
  assign commit  = go & ~(inv_en & inv_any);

  assign raised = '{inx: flag_inx, unf: flag_unf, ovf: flag_ovf,
                    isi: flag_isi, imz: flag_imz, snan: flag_snan};

  qfp_status_upd u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (go),
    .raised   (raised),
    .inv_any  (inv_any),
    .inx      (flag_inx),
    .inc      (flag_inc),
    .sticky   (stk_q),
    .exc_sum  (exc_sum),
    .frac_rnd (frac_rnd),
    .frac_inx (frac_inx)
  );

  assign sticky = stk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      trap      <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      res_class <= '0;
    end else begin
      wr_en <= commit;
      trap  <= in_valid & ~fac_en;
      if (commit) begin
        wr_idx    <= upper(dst_fld);
        wr_data   <= neg_val;
        res_class <= neg_cls;
      end
    end
  end
endmodule

// File: rtl/qfp_commit_chk.sv
module qfp_commit_chk #(
  parameter int FLDW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          fac_en,
  input logic          inv_en,
  input logic          flag_snan,
  input logic          flag_imz,
  input logic          flag_isi,
  input logic          flag_inx,
  input logic          flag_inc,
  input logic          wr_en,
  input logic [FLDW:0] wr_idx,
  input logic          trap,
  input logic [5:0]    sticky,
  input logic          exc_sum,
  input logic          frac_rnd,
  input logic          frac_inx,
  input logic [4:0]    res_class
);
  assert_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fac_en |=> trap && !wr_en);

  assert_trap_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fac_en |=> $stable(sticky) && $stable(exc_sum) &&
      $stable(frac_rnd) && $stable(frac_inx) && $stable(res_class));

  assert_upper_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx[FLDW]);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fac_en && inv_en && (flag_snan || flag_imz || flag_isi)
      |=> !wr_en && $stable(res_class));

  assert_sum_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|sticky) |-> exc_sum);

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(exc_sum));

  assert_frac_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fac_en |=>
      frac_inx == $past(flag_inx && !(flag_snan || flag_imz || flag_isi)) &&
      frac_rnd == $past(flag_inc && !(flag_snan || flag_imz || flag_isi)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en && !trap);
endmodule

bind qfp_commit qfp_commit_chk #(.FLDW(FLDW)) u_chk (.*);

// File: tb/qfp_commit_tb.sv
`timescale 1ns/1ps
module qfp_commit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, fac_en = 1, inv_en = 0;
  logic [127:0] res_in = '0;
  logic [4:0] dst_fld = 0, src_a_fld = 0, src_b_fld = 0;
  logic f_snan = 0, f_imz = 0, f_isi = 0, f_ovf = 0, f_unf = 0, f_inx = 0, f_inc = 0;
  logic [5:0] rd_a_idx, rd_b_idx, wr_idx, sticky;
  logic wr_en, trap, exc_sum, frac_rnd, frac_inx;
  logic [127:0] wr_data;
  logic [4:0] res_class;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  qfp_commit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fac_en(fac_en), .inv_en(inv_en),
    .res_in(res_in), .dst_fld(dst_fld), .src_a_fld(src_a_fld), .src_b_fld(src_b_fld),
    .flag_snan(f_snan), .flag_imz(f_imz), .flag_isi(f_isi), .flag_ovf(f_ovf),
    .flag_unf(f_unf), .flag_inx(f_inx), .flag_inc(f_inc),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .trap(trap), .sticky(sticky), .exc_sum(exc_sum),
    .frac_rnd(frac_rnd), .frac_inx(frac_inx), .res_class(res_class)
  );

  typedef struct packed {
    logic [127:0] din;
    logic [127:0] dout;
    logic [4:0]   cls;
    logic         inv;
    logic [6:0]   fl;   // {snan,imz,isi,ovf,unf,inx,inc}
    logic         we;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 128'hBFFF_0000_0000_0000_0000_0000_0000_0000, 5'b01000, 1'b0, 7'h00, 1'b1},
    '{128'hC000_0000_0000_0000_0000_0000_0000_0000, 128'h4000_0000_0000_0000_0000_0000_0000_0000, 5'b00100, 1'b0, 7'h00, 1'b1},
    '{128'h0000_0000_0000_0000_0000_0000_0000_0000, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 5'b10010, 1'b0, 7'h00, 1'b1},
    '{128'h8000_0000_0000_0000_0000_0000_0000_0000, 128'h0000_0000_0000_0000_0000_0000_0000_0000, 5'b00010, 1'b0, 7'h00, 1'b1},
    '{128'h0000_0000_0000_0000_0000_0000_0000_0001, 128'h8000_0000_0000_0000_0000_0000_0000_0001, 5'b11000, 1'b0, 7'h00, 1'b1},
    '{128'h8000_0000_0000_0000_0000_0000_0000_0001, 128'h0000_0000_0000_0000_0000_0000_0000_0001, 5'b10100, 1'b0, 7'h00, 1'b1},
    '{128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 5'b01001, 1'b0, 7'h00, 1'b1},
    '{128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 5'b00101, 1'b0, 7'h00, 1'b1},
    '{128'h7FFF_8000_0000_0000_0000_0000_0000_0000, 128'h7FFF_8000_0000_0000_0000_0000_0000_0000, 5'b10001, 1'b0, 7'h00, 1'b1},
    '{128'hFFFF_0000_0000_0000_0000_0000_0000_0001, 128'hFFFF_0000_0000_0000_0000_0000_0000_0001, 5'b10001, 1'b0, 7'h00, 1'b1},
    '{128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 128'h0,                                     5'b10001, 1'b1, 7'h40, 1'b0},
    '{128'h4000_0000_0000_0000_0000_0000_0000_0000, 128'hC000_0000_0000_0000_0000_0000_0000_0000, 5'b01000, 1'b0, 7'h20, 1'b1}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_flags(input logic [6:0] fl);
    {f_snan, f_imz, f_isi, f_ovf, f_unf, f_inx, f_inc} = fl;
  endtask

  // Drive one instruction for one cycle; on return outputs reflect it.
  task automatic issue(input logic fe, input logic ie, input logic [127:0] d,
                       input logic [6:0] fl, input logic [4:0] dst);
    @(negedge clk);
    in_valid = 1; fac_en = fe; inv_en = ie; res_in = d; dst_fld = dst;
    set_flags(fl);
    @(negedge clk);
    in_valid = 0; set_flags(7'h00); fac_en = 1; inv_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk("R10 wr_en", 128'(wr_en), 0);
    chk("R10 trap", 128'(trap), 0);
    chk("R10 sticky", 128'(sticky), 0);
    chk("R10 exc_sum", 128'(exc_sum), 0);
    chk("R10 frac", 128'({frac_rnd, frac_inx}), 0);
    chk("R10 class", 128'(res_class), 0);

    // R2 read index mapping at field extremes
    src_a_fld = 5'd0; src_b_fld = 5'd31; #1;
    chk("R2 rd_a_idx", 128'(rd_a_idx), 32);
    chk("R2 rd_b_idx", 128'(rd_b_idx), 63);

    // Table walk: R3 negation, R4 class, R5 suppression, R2 write index
    for (int i = 0; i < NV; i++) begin
      logic [4:0] dst;
      dst = (i == 0) ? 5'd31 : 5'(i);
      issue(1'b1, VT[i].inv, VT[i].din, VT[i].fl, dst);
      chk($sformatf("R5 wr_en vec%0d", i), 128'(wr_en), 128'(VT[i].we));
      chk($sformatf("R4 class vec%0d", i), 128'(res_class), 128'(VT[i].cls));
      if (VT[i].we) begin
        chk($sformatf("R3 data vec%0d", i), wr_data, VT[i].dout);
        chk($sformatf("R2 wr_idx vec%0d", i), 128'(wr_idx), 128'(dst) + 32);
      end
    end
    @(negedge clk);
    chk("R9 idle wr_en", 128'(wr_en), 0);

    // Directed status tests
    do_reset();
    issue(1'b1, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h00, 5'd1);
    chk("R7 no flags no sum", 128'(exc_sum), 0);
    chk("R6 no flags sticky", 128'(sticky), 0);

    issue(1'b1, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h08, 5'd1);
    chk("R6 ovf sticky", 128'(sticky), 6'b001000);
    chk("R7 sum set", 128'(exc_sum), 1);
    chk("R8 frac after ovf", 128'({frac_rnd, frac_inx}), 0);

    issue(1'b1, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h03, 5'd1);
    chk("R6 inx sticky", 128'(sticky), 6'b101000);
    chk("R8 frac set", 128'({frac_rnd, frac_inx}), 2'b11);

    // R1 disabled facility with snan raised
    issue(1'b0, 1'b1, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h40, 5'd2);
    chk("R1 trap", 128'(trap), 1);
    chk("R1 no write", 128'(wr_en), 0);
    chk("R1 sticky kept", 128'(sticky), 6'b101000);
    chk("R1 frac kept", 128'({frac_rnd, frac_inx}), 2'b11);
    chk("R1 class kept", 128'(res_class), 5'b01000);
    @(negedge clk);
    chk("R9 trap drops", 128'(trap), 0);

    issue(1'b1, 1'b0, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 7'h00, 5'd1);
    chk("R8 frac overwritten", 128'({frac_rnd, frac_inx}), 0);
    chk("R6 sticky retained", 128'(sticky), 6'b101000);

    // Invalid masks frac bits; inv_en=0 still writes
    issue(1'b1, 1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_0000, 7'h23, 5'd4);
    chk("R8 frac masked by imz", 128'({frac_rnd, frac_inx}), 0);
    chk("R6 imz sticky", 128'(sticky), 6'b101010);
    chk("R5 inv_en=0 writes", 128'(wr_en), 1);
    chk("R4 class -zero", 128'(res_class), 5'b10010);

    // Enabled inf-minus-inf: no write, class frozen
    issue(1'b1, 1'b1, 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 7'h10, 5'd5);
    chk("R5 isi no write", 128'(wr_en), 0);
    chk("R5 isi class frozen", 128'(res_class), 5'b10010);
    chk("R6 isi sticky", 128'(sticky), 6'b101110);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule